// File: doc/BRIEF.md
# Three-Phase Complementary Output Controller

This block drives six output pins arranged as three phase pairs (U, V, W). Each pair has a negative-phase pin and a positive-phase pin. A pair's requested state comes from one of two places. The first is a per-phase timer flip-flop, set and cleared by compare-match strobes from an external counter. The second is a per-phase software port bit. Software output always overrides the timer. When software output is switched off while the timer keeps running, each phase keeps its last software level until that phase sees its first compare strobe. Only then does it follow its flip-flop.

Every change of a pair's requested state passes through dead-time insertion. The pin that was active goes inactive at once. The newly requested pin stays inactive for a programmable number of clocks. Software-driven changes get this treatment too. Active levels come from polarity inputs: one common bit for all negative-phase pins, and one bit for each positive-phase pin. When both the timer and software output are off, all six pins rest at their inactive levels.

Top module: `tpc_out_ctrl`

## Requirements
- R1: Out of reset, and whenever `tmr_en_i` and `sw_en_i` are both 0, every pin sits at its inactive level. The inactive level is `~neg_pol_i` for the negative-phase pins and `~pos_pol_i[p]` for the positive-phase pins. The reaction to the off condition comes one clock after it is sampled, with no dead time.
- R2: While `sw_en_i`=1, phase p follows `sw_port_i[p]`, whatever the timer is doing. Port bit 1 makes the positive pin active. Port bit 0 makes the negative pin active.
- R3: While `tmr_en_i`=1, a `set_i[p]` strobe sets phase p's flip-flop to 1 and a `clr_i[p]` strobe clears it to 0; set wins when both are high. Strobes are ignored while `tmr_en_i`=0. With the timer on and software off, the flip-flop value selects the active pin with the same mapping as R2.
- R4: If `sw_en_i` falls while `tmr_en_i`=1, each phase keeps its last software level. It changes only once that phase receives its first set or clear strobe.
- R5: When a pair's requested state changes, the new request is sampled at clock edge k. The previously active pin goes inactive at edge k. The newly requested pin becomes active at edge k+D, where D is `dead_cnt_i` sampled at edge k, and it is inactive before that edge.
- R6: A request that changes again during a dead-time interval restarts the interval, with the latest requested state as the target.
- R7: The two pins of a pair are never active at the same time.
- R8: The active level of a negative-phase pin is `neg_pol_i`. The active level of positive-phase pin p is `pos_pol_i[p]`. Each inactive level is the inverse of the active level.
- R9: With D=0, the new pin becomes active at edge k itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tmr_en_i | input | 1 | Timer operation enable |
| sw_en_i | input | 1 | Software output enable |
| sw_port_i | input | 3 | Software level per phase: bit 0 = U, bit 1 = V, bit 2 = W |
| set_i | input | 3 | Compare-match set strobe per phase |
| clr_i | input | 3 | Compare-match clear strobe per phase |
| neg_pol_i | input | 1 | Common active level of the negative-phase pins |
| pos_pol_i | input | 3 | Active level of each positive-phase pin |
| dead_cnt_i | input | 8 | Dead-time length in clocks |
| pin_o | output | 6 | Pin levels: bit 2p = negative pin of phase p, bit 2p+1 = positive pin of phase p |

## Verification
The bench targets the hand-back window after software output is released. A design that switched straight to the timer would jump a phase to its flip-flop level before that phase saw a strobe. The bench also checks the exact edge at which dead time ends, at both D=3 and D=0. An off-by-one counter would show up there as one clock too many or too few with both pins inactive. A request that reverses mid-interval must restart the count, and a design that kept counting would turn the pin on too early. Finally, the bench checks that a set and a clear arriving together resolve to set, that strobes with the timer off leave the flip-flops alone, and that mixed polarity settings produce the correct active and inactive levels on every pin.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int unsigned NUM_PHASES = 3;
  localparam int unsigned NUM_PINS   = 2 * NUM_PHASES;

  typedef struct packed {
    logic on;   // pair driven (one pin active)
    logic val;  // 1: positive active, 0: negative active
  } phase_req_t;
endpackage

// File: rtl/tpc_phase_src.sv
module tpc_phase_src
  import tpc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tmr_en_i,
  input  logic       sw_en_i,
  input  logic       sw_bit_i,
  input  logic       set_i,
  input  logic       clr_i,
  output phase_req_t req_o
);
  logic ff_q;
  logic hold_q;
  logic sw_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q <= 1'b0;
    end else if (tmr_en_i) begin
      if (set_i)      ff_q <= 1'b1;
      else if (clr_i) ff_q <= 1'b0;
    end
  end

  // hold_q armed while software owns the pins; released by first strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= 1'b0;
      sw_val_q <= 1'b0;
    end else begin
      if (sw_en_i) begin
        hold_q   <= 1'b1;
        sw_val_q <= sw_bit_i;
      end else if (!tmr_en_i || set_i || clr_i) begin
        hold_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (sw_en_i) begin
      req_o.on  = 1'b1;
      req_o.val = sw_bit_i;
    end else if (tmr_en_i) begin
      req_o.on  = 1'b1;
      req_o.val = hold_q ? sw_val_q : ff_q;
    end else begin
      req_o.on  = 1'b0;
      req_o.val = 1'b0;
    end
  end

  a_r3_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_en_i && set_i) |=> ff_q);

  a_r3_off_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_en_i |=> $stable(ff_q));

  a_r4_hold_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sw_en_i) && !sw_en_i && tmr_en_i) |-> (req_o.val == $past(sw_bit_i)));

  a_r2_sw_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_en_i |-> (req_o.on && (req_o.val == sw_bit_i)));
endmodule

// File: rtl/tpc_dead_time.sv
module tpc_dead_time
  import tpc_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  phase_req_t      req_i,
  input  logic [DT_W-1:0] dead_cnt_i,
  output logic            pos_act_o,
  output logic            neg_act_o
);
  logic            have_q;
  logic            tgt_q;
  logic            act_q;
  logic [DT_W-1:0] cnt_q;
  logic            change;

  assign change = req_i.on && (!have_q || (req_i.val != tgt_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      tgt_q  <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (!req_i.on) begin
      have_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (change) begin
      // (re)start interval toward latest target
      have_q <= 1'b1;
      tgt_q  <= req_i.val;
      act_q  <= (dead_cnt_i == '0);
      cnt_q  <= dead_cnt_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == DT_W'(1)) act_q <= 1'b1;
    end
  end

  assign pos_act_o = act_q &  tgt_q;
  assign neg_act_o = act_q & ~tgt_q;

  a_r7_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_act_o && neg_act_o));

  a_r1_off_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i.on |=> (!pos_act_o && !neg_act_o));

  a_r5_gap_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (change && (dead_cnt_i != '0)) |=> (!pos_act_o && !neg_act_o));

  a_r9_zero_dt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (change && (dead_cnt_i == '0)) |=>
      ((pos_act_o == $past(req_i.val)) && (neg_act_o == !$past(req_i.val))));

  a_r6_steady_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i.on && !change && act_q) |=> $stable(act_q));
endmodule

// File: rtl/tpc_pol_map.sv
module tpc_pol_map (
  input  logic pos_act_i,
  input  logic neg_act_i,
  input  logic pos_pol_i,
  input  logic neg_pol_i,
  output logic pos_pin_o,
  output logic neg_pin_o
);
  assign pos_pin_o = pos_act_i ? pos_pol_i : ~pos_pol_i;
  assign neg_pin_o = neg_act_i ? neg_pol_i : ~neg_pol_i;
endmodule

// File: rtl/tpc_out_ctrl.sv
module tpc_out_ctrl
  import tpc_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tmr_en_i,
  input  logic                  sw_en_i,
  input  logic [NUM_PHASES-1:0] sw_port_i,
  input  logic [NUM_PHASES-1:0] set_i,
  input  logic [NUM_PHASES-1:0] clr_i,
  input  logic                  neg_pol_i,
  input  logic [NUM_PHASES-1:0] pos_pol_i,
  input  logic [DT_W-1:0]       dead_cnt_i,
  output logic [NUM_PINS-1:0]   pin_o
);
  phase_req_t [NUM_PHASES-1:0] req;
  logic       [NUM_PHASES-1:0] pos_act;
  logic       [NUM_PHASES-1:0] neg_act;

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    tpc_phase_src u_src (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tmr_en_i (tmr_en_i),
      .sw_en_i  (sw_en_i),
      .sw_bit_i (sw_port_i[p]),
      .set_i    (set_i[p]),
      .clr_i    (clr_i[p]),
      .req_o    (req[p])
    );

    tpc_dead_time #(.DT_W(DT_W)) u_dt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req[p]),
      .dead_cnt_i (dead_cnt_i),
      .pos_act_o  (pos_act[p]),
      .neg_act_o  (neg_act[p])
    );

    tpc_pol_map u_pol (
      .pos_act_i (pos_act[p]),
      .neg_act_i (neg_act[p]),
      .pos_pol_i (pos_pol_i[p]),
      .neg_pol_i (neg_pol_i),
      .pos_pin_o (pin_o[2*p+1]),
      .neg_pin_o (pin_o[2*p])
    );
  end

  a_r8_pair_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((pin_o[1] == pos_pol_i[0]) && (pin_o[0] == neg_pol_i)));
endmodule

// File: tb/tpc_out_ctrl_tb.sv
module tpc_out_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       tmr;
    logic       sw;
    logic [2:0] port;
    logic [2:0] set;
    logic [2:0] clr;
    logic [5:0] exp;
    logic [3:0] req;
  } vec_t;

  // defaults: D=2, neg_pol=1, pos_pol=111; pin 2p=neg, 2p+1=pos
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 3'b000, 3'b000, 3'b000, 6'b000000, 4'd1}, // R1 off
    '{1'b0, 1'b1, 3'b101, 3'b000, 3'b000, 6'b100110, 4'd2}, // R2
    '{1'b0, 1'b1, 3'b010, 3'b000, 3'b000, 6'b011001, 4'd2}, // R2
    '{1'b1, 1'b1, 3'b010, 3'b111, 3'b000, 6'b011001, 4'd2}, // R2 sw beats timer
    '{1'b1, 1'b0, 3'b000, 3'b000, 3'b000, 6'b011001, 4'd4}, // R4 hold
    '{1'b1, 1'b0, 3'b000, 3'b001, 3'b000, 6'b011010, 4'd4}, // R4 U released only
    '{1'b1, 1'b0, 3'b000, 3'b000, 3'b110, 6'b010110, 4'd4}, // R4 V,W released
    '{1'b1, 1'b0, 3'b000, 3'b100, 3'b000, 6'b100110, 4'd3}, // R3 W set
    '{1'b0, 1'b0, 3'b000, 3'b000, 3'b000, 6'b000000, 4'd1}, // R1 off
    '{1'b1, 1'b0, 3'b000, 3'b000, 3'b000, 6'b100110, 4'd3}, // R3 FF, no hold
    '{1'b1, 1'b0, 3'b000, 3'b010, 3'b010, 6'b101010, 4'd3}, // R3 set wins
    '{1'b0, 1'b0, 3'b000, 3'b000, 3'b111, 6'b000000, 4'd3}, // R3 strobes ignored
    '{1'b1, 1'b0, 3'b000, 3'b000, 3'b000, 6'b101010, 4'd3}  // R3 FF unchanged
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr_en = 1'b0;
  logic       sw_en = 1'b0;
  logic [2:0] sw_port = '0;
  logic [2:0] set_s = '0;
  logic [2:0] clr_s = '0;
  logic       neg_pol = 1'b1;
  logic [2:0] pos_pol = 3'b111;
  logic [7:0] dead_cnt = 8'd2;
  logic [5:0] pin;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tpc_out_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tmr_en_i(tmr_en), .sw_en_i(sw_en),
    .sw_port_i(sw_port), .set_i(set_s), .clr_i(clr_s), .neg_pol_i(neg_pol),
    .pos_pol_i(pos_pol), .dead_cnt_i(dead_cnt), .pin_o(pin)
  );

  task automatic check(input logic [5:0] act, input logic [5:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2);
    check(pin, 6'b000000, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    edges(2);
    check(pin, 6'b000000, "R1 idle after reset");

    for (int i = 0; i < NV; i++) begin
      tmr_en  = VECS[i].tmr;
      sw_en   = VECS[i].sw;
      sw_port = VECS[i].port;
      set_s   = VECS[i].set;
      clr_s   = VECS[i].clr;
      @(posedge clk);
      @(negedge clk);
      set_s = '0;
      clr_s = '0;
      edges(3);
      check(pin, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R5: exact dead-time edge, D=3
    tmr_en = 1'b0; sw_en = 1'b1; sw_port = 3'b000; dead_cnt = 8'd3;
    edges(6);
    check(pin, 6'b010101, "R2 all negative");
    sw_port = 3'b001;
    edges(1);
    check({4'b0, pin[1:0]}, 6'b0, "R5 old pin off at edge k");
    edges(2);
    check({4'b0, pin[1:0]}, 6'b0, "R5 still dead at k+2");
    edges(1);
    check({4'b0, pin[1:0]}, 6'b000010, "R5 new pin on at k+3");
    check(pin[5:2], 4'b0101, "R7 other pairs untouched");

    // R6: reversal during interval restarts count
    sw_port = 3'b000;
    edges(2);
    sw_port = 3'b001;
    edges(3);
    check({4'b0, pin[1:0]}, 6'b0, "R6 restarted interval still dead");
    edges(1);
    check({4'b0, pin[1:0]}, 6'b000010, "R6 on after full restart");

    // R9: zero dead time
    dead_cnt = 8'd0;
    sw_port = 3'b000;
    edges(1);
    check({4'b0, pin[1:0]}, 6'b000001, "R9 immediate switch");

    // R8: polarity
    dead_cnt = 8'd2; sw_port = 3'b101; neg_pol = 1'b0; pos_pol = 3'b010;
    edges(4);
    check(pin, 6'b010001, "R8 mixed polarity driven");
    sw_en = 1'b0;
    edges(1);
    check(pin, 6'b110111, "R8 R1 mixed polarity idle");

    // R1: reset mid-operation
    sw_en = 1'b1; neg_pol = 1'b1; pos_pol = 3'b111;
    edges(4);
    rst_n = 1'b0;
    #1;
    check(pin, 6'b000000, "R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    sw_en = 1'b0;
    edges(2);
    check(pin, 6'b000000, "R1 after re-reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule